// File: doc/BRIEF.md
# Exact Recency Order Keeper for One Cache Set

This block holds the replacement state of one set of a four-way associative cache. It keeps the ways in exact order from most recently used to least recently used. The state is a move-to-front list of 2-bit way numbers, eight bits in all, with a presence flag for each slot. When a way is referenced, it is taken out of the list wherever it sits and placed in front. The ways it passes over each move back one slot.

The cache controller reports each hit with a single-cycle touch strobe and the way number. On a miss it raises the allocate strobe. The block then names a way to fill, either a way that has never been used or the one in the last slot, and moves that way to the front. Because the state changes in a single cycle, the block never stalls. Both strobes are plain control pins with no ready path back to the controller: every strobe is taken on the clock edge where it is seen. Tag compare and data storage belong to the instantiating design, which keeps one copy of this block per set.

Top module: `lru_stack_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it falls, the list clears: `slot_valid` is 0, `order` is 0 and `victim_way` is 0.
- R2: On the clock edge where `touch_valid` is high, the way on `touch_way` becomes the entry in slot 0, and `slot_valid[0]` is set.
- R3: A touched way that is already listed is removed from its slot. The entries in front of that slot move back one slot each, and the entries behind it keep their places. A way not yet listed is inserted in front, and every listed entry moves back one slot.
- R4: A touch of the way already in slot 0 leaves `order` and `slot_valid` unchanged.
- R5: When all four slots are present, `victim_way` equals the way in slot 3, the least recently used entry.
- R6: While any slot is empty, `victim_way` is the lowest numbered way that no present slot holds.
- R7: An `alloc_req` without `touch_valid` moves the current `victim_way` to slot 0 on the next edge, exactly as a touch of that way would. From the full list with slot 0 to slot 3 holding 3,2,0,1, the result is 1,3,2,0.
- R8: When `touch_valid` and `alloc_req` are both high, the touch is applied and the allocate request is ignored.
- R9: With both strobes low, `order` and `slot_valid` hold their values.
- R10: `order[2i+1:2i]` is the way in slot i, where slot 0 is most recent. Bits of slots that are not present read 0. `victim_way` is combinational from the current state.
- R11: Present slots are always contiguous from slot 0, and no way appears in two present slots. Each reference to a way not yet listed adds exactly one present slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| touch_valid | input | 1 | A hit in this set during this cycle |
| touch_way | input | 2 | Way that was hit |
| alloc_req | input | 1 | Miss: allocate the victim and make it most recent |
| victim_way | output | 2 | Way to replace next |
| order | output | 8 | Recency list, slot 0 (most recent) in bits 1:0 |
| slot_valid | output | 4 | Presence flag for each slot |

## Verification
The hardest situation to reach from the ports is a full list in which the touched way sits in the middle. Only that case moves some entries and leaves the rest in place. Others are an allocation landing on a list that already holds four ways, and a touch and an allocation arriving in the same cycle. The stimulus first replays a fixed eight-touch ordering from empty and checks every intermediate list. It then builds a known full order and allocates from it, and after that runs a long pseudo-random mix of touches, allocations, simultaneous strobes and idle cycles. A reset in the middle of the run returns the list to empty so the free-way selection is exercised a second time.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Kind of update applied to the recency list on an edge.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_TOUCH = 2'd1,
    OP_ALLOC = 2'd2
  } lru_op_e;
endpackage

// File: rtl/lru_op_select.sv
module lru_op_select #(
  parameter int unsigned NW = 2
) (
  input  logic            touch_valid,
  input  logic [NW-1:0]   touch_way,
  input  logic            alloc_req,
  input  logic [NW-1:0]   victim_way,
  output lru_pkg::lru_op_e op,
  output logic [NW-1:0]   op_way
);
  // Touch wins over allocate (R8).
  always_comb begin
    if (touch_valid) begin
      op     = lru_pkg::OP_TOUCH;
      op_way = touch_way;
    end else if (alloc_req) begin
      op     = lru_pkg::OP_ALLOC;
      op_way = victim_way;
    end else begin
      op     = lru_pkg::OP_IDLE;
      op_way = '0;
    end
  end
endmodule

// File: rtl/lru_stack_next.sv
module lru_stack_next #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned NW   = 2
) (
  input  logic [WAYS*NW-1:0] cur_names,
  input  logic [WAYS-1:0]    cur_vld,
  input  logic               upd,
  input  logic [NW-1:0]      name,
  output logic [WAYS*NW-1:0] nxt_names,
  output logic [WAYS-1:0]    nxt_vld
);
  int   pos;
  logic found;

  // The slot the name is pulled from: its current slot, else the first
  // empty slot, else the bottom slot (dropped on a full list).
  always_comb begin
    pos   = WAYS - 1;
    found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && cur_vld[i] && cur_names[i*NW +: NW] == name) begin
        pos   = i;
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int i = WAYS - 1; i >= 0; i--) begin
        if (!cur_vld[i]) pos = i;
      end
    end
  end

  // Slot 0 receives the referenced name.
  always_comb begin
    if (upd) begin
      nxt_names[NW-1:0] = name;
      nxt_vld[0]        = 1'b1;
    end else begin
      nxt_names[NW-1:0] = cur_names[NW-1:0];
      nxt_vld[0]        = cur_vld[0];
    end
  end

  // Slots up to the pulled one shift back by one; deeper slots keep theirs.
  for (genvar g = 1; g < WAYS; g++) begin : g_slot
    always_comb begin
      if (upd && g <= pos) begin
        nxt_names[g*NW +: NW] = cur_names[(g-1)*NW +: NW];
        nxt_vld[g]            = cur_vld[g-1];
      end else begin
        nxt_names[g*NW +: NW] = cur_names[g*NW +: NW];
        nxt_vld[g]            = cur_vld[g];
      end
    end
  end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned NW   = 2
) (
  input  logic [WAYS*NW-1:0] names,
  input  logic [WAYS-1:0]    vld,
  output logic [NW-1:0]      victim,
  output logic               full
);
  logic [WAYS-1:0] present;

  // Mark every way that some present slot holds.
  always_comb begin
    present = '0;
    for (int s = 0; s < WAYS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (vld[s] && names[s*NW +: NW] == NW'(w)) present[w] = 1'b1;
      end
    end
  end

  assign full = &vld;

  always_comb begin
    victim = names[(WAYS-1)*NW +: NW];
    if (!full) begin
      victim = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!present[w]) victim = NW'(w);
      end
    end
  end
endmodule

// File: rtl/lru_stack_tracker.sv
module lru_stack_tracker #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned NW    = $clog2(WAYS),
  localparam int unsigned ORD_W = WAYS * NW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [NW-1:0]    touch_way,
  input  logic             alloc_req,
  output logic [NW-1:0]    victim_way,
  output logic [ORD_W-1:0] order,
  output logic [WAYS-1:0]  slot_valid
);
  lru_pkg::lru_op_e  op;
  logic [NW-1:0]     op_way;
  logic [ORD_W-1:0]  names_q, names_d;
  logic [WAYS-1:0]   vld_q, vld_d;
  logic              full;

  lru_victim_pick #(.WAYS(WAYS), .NW(NW)) u_pick (
    .names (names_q),
    .vld   (vld_q),
    .victim(victim_way),
    .full  (full)
  );

  lru_op_select #(.NW(NW)) u_sel (
    .touch_valid(touch_valid),
    .touch_way  (touch_way),
    .alloc_req  (alloc_req),
    .victim_way (victim_way),
    .op         (op),
    .op_way     (op_way)
  );

  lru_stack_next #(.WAYS(WAYS), .NW(NW)) u_next (
    .cur_names(names_q),
    .cur_vld  (vld_q),
    .upd      (op != lru_pkg::OP_IDLE),
    .name     (op_way),
    .nxt_names(names_d),
    .nxt_vld  (vld_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      names_q <= '0;
      vld_q   <= '0;
    end else begin
      names_q <= names_d;
      vld_q   <= vld_d;
    end
  end

  assign order      = names_q;
  assign slot_valid = vld_q;

  // R11: contiguous presence from slot 0, and no duplicated way.
  always_comb begin
    if (rst_n) begin
      p_contig_r11: assert ((vld_q & (vld_q + 1'b1)) == '0);
      for (int a = 0; a < WAYS; a++) begin
        for (int b = a + 1; b < WAYS; b++) begin
          p_distinct_r11: assert (!(vld_q[a] && vld_q[b] &&
                                    names_q[a*NW +: NW] == names_q[b*NW +: NW]));
        end
      end
    end
  end

  // R2: a touched way lands in slot 0.
  p_touch_mru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid |=> (order[NW-1:0] == $past(touch_way)) && slot_valid[0]);

  // R7: an allocation installs the victim as most recent.
  p_alloc_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !touch_valid) |=> order[NW-1:0] == $past(victim_way));

  // R6: allocating into a list with free slots grows it by one.
  p_alloc_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !touch_valid && !(&slot_valid)) |=>
      $countones(slot_valid) == $countones($past(slot_valid)) + 1);

  // R9: no strobe, no change.
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!touch_valid && !alloc_req) |=> $stable(order) && $stable(slot_valid));

  // R4: touching the head keeps the list.
  p_head_touch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && slot_valid[0] && touch_way == order[NW-1:0]) |=>
      $stable(order) && $stable(slot_valid));

  // R5: a full list offers its bottom entry.
  p_full_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> victim_way == order[ORD_W-1 -: NW]);
endmodule

// File: tb/lru_stack_tracker_test.sv
module lru_stack_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       touch_valid = 1'b0;
  logic [1:0] touch_way = 2'd0;
  logic       alloc_req = 1'b0;
  logic [1:0] victim_way;
  logic [7:0] order;
  logic [3:0] slot_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lru_stack_tracker uut (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_way(touch_way),
    .alloc_req(alloc_req), .victim_way(victim_way), .order(order),
    .slot_valid(slot_valid)
  );

  typedef struct {
    logic [7:0] ord;
    logic [3:0] vld;
    logic [1:0] vic;
    string      tag;
    string      vtag;
  } exp_t;

  exp_t exp_q[$];
  int   model[$];   // index 0 is most recent

  function automatic logic [1:0] model_victim();
    bit seen[4];
    if (model.size() == 4) return 2'(model[3]);
    foreach (seen[i]) seen[i] = 1'b0;
    foreach (model[i]) seen[model[i]] = 1'b1;
    for (int w = 0; w < 4; w++) if (!seen[w]) return 2'(w);
    return 2'd0;
  endfunction

  function automatic void model_ref(int w);
    foreach (model[i]) begin
      if (model[i] == w) begin
        model.delete(i);
        break;
      end
    end
    model.push_front(w);
    if (model.size() > 4) void'(model.pop_back());
  endfunction

  function automatic exp_t model_snapshot(string tag);
    exp_t e;
    e.ord = '0;
    e.vld = '0;
    foreach (model[i]) begin
      e.ord[i*2 +: 2] = 2'(model[i]);
      e.vld[i] = 1'b1;
    end
    e.vic  = model_victim();
    e.tag  = tag;
    e.vtag = (model.size() == 4) ? "R5" : "R6";
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected state.
  task automatic step(input bit a, input logic [1:0] w, input bit r);
    string tag;
    @(negedge clk);
    touch_valid = a;
    touch_way   = w;
    alloc_req   = r;
    if (a) begin
      if (model.size() > 0 && model[0] == int'(w)) tag = r ? "R8 R4" : "R4 R10";
      else tag = r ? "R8 R3" : "R2 R3 R10";
      model_ref(int'(w));
    end else if (r) begin
      tag = "R7 R11";
      model_ref(int'(model_victim()));
    end else begin
      tag = "R9";
    end
    exp_q.push_back(model_snapshot(tag));
    @(posedge clk);
    #1;
    touch_valid = 1'b0;
    alloc_req   = 1'b0;
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(order == e.ord, {e.tag, " order"}, order, e.ord);
        check(slot_valid == e.vld, {e.tag, " slot_valid"}, slot_valid, e.vld);
        check(victim_way == e.vic, {e.vtag, " victim"}, victim_way, e.vic);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #5;
    // R1: cleared state
    check(slot_valid == 4'h0, "R1 slot_valid", slot_valid, 0);
    check(order == 8'h00, "R1 order", order, 0);
    check(victim_way == 2'd0, "R1 victim", victim_way, 0);
    model.delete();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int unsigned lcg = 32'h1234_5678;
    do_reset();
    // Fixed ordering C,D,A,B,A,C,B,D with A=0 B=1 C=2 D=3.
    step(1, 2, 0); step(1, 3, 0); step(1, 0, 0); step(1, 1, 0);
    step(1, 0, 0); step(1, 2, 0); step(1, 1, 0); step(1, 3, 0);
    #6;
    check(order == 8'h27, "R3 final order D,B,C,A", order, 8'h27);
    step(1, 3, 0);   // R4: repeat the head
    step(0, 0, 0);   // R9
    step(0, 0, 0);
    // Build D,C,A,B then allocate: expect B,D,C,A.
    step(1, 1, 0); step(1, 0, 0); step(1, 2, 0); step(1, 3, 0);
    #6;
    check(victim_way == 2'd1, "R5 bottom victim", victim_way, 1);
    step(0, 0, 1);
    #6;
    check(order == 8'h2D, "R7 alloc on full list", order, 8'h2D);
    step(1, 2, 1);   // R8: both strobes
    // Refill from empty through allocations only.
    do_reset();
    step(0, 0, 1); step(0, 0, 1); step(1, 3, 0); step(0, 0, 1); step(0, 0, 1);
    do_reset();
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[20], lcg[22:21], lcg[24] & lcg[25]);
    end
    @(posedge clk);
    #8;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule